// File: doc/BRIEF.md
# Scatter-Gather Receive Descriptor Writer

This block places one incoming packet into memory by following a linked chain of descriptors. When a packet source offers a packet of known length, the block starts at its current descriptor pointer. From each descriptor it reads the link, the buffer address, the control word and the status word. It then asks an external data mover to copy a chunk into that buffer. The chunk is no larger than the descriptor allows and no larger than what is left of the packet. The walk goes on through further descriptors until the packet is used up, the tail descriptor is reached, or a descriptor that is already complete is found.

Each descriptor that is used gets its status word written back with flags added to it. Start-of-frame is marked on the first descriptor of the packet. End-of-frame, plus five application words, go to the descriptor that takes the final byte. The five application words come from a side stream ahead of time. They are held in a small register file that is updated only when a side-stream frame has exactly five beats. At the end of each walk the block reports how many bytes were accepted.

Descriptor layout, in 32-bit words from the descriptor pointer (pointers are word addresses):
- offset 0: link to the next descriptor
- offset 1: buffer address
- offset 2: control (length in bits 22:0)
- offset 3: status
- offsets 4 to 8: application words

Top module: `rx_sg_writer`

## Requirements
- R1: `pkt_ready` is high only when `run_en` is 1, `idle` is 0 and no packet walk is in progress. After reset `run_en` is 0, so `pkt_ready` is 0.
- R2: For each descriptor used, exactly one mover request is issued. The request carries the buffer address (word at offset 1). Its length is the smaller of control bits 22:0 (word at offset 2) and the bytes still remaining in the packet.
- R3: Each used descriptor has its status word (offset 3) written back. The written value is the fetched status with bit 31 (complete) set; every other fetched bit is kept.
- R4: Bit 27 (start-of-frame) is set in the written status of the first descriptor of a packet only.
- R5: The descriptor that takes the last byte of the packet gets bit 26 (end-of-frame). The five held application words are written to its offsets 4 to 8, in capture order. `done_eof` is 1 for that walk.
- R6: `halted` is 1 after reset and clears on a rising edge of `run_en`. If a fetched status word has bit 31 set, `halted` becomes 1, the walk ends, and that descriptor is not written.
- R7: When the descriptor at the tail pointer has been written back, `idle` becomes 1 and the walk ends, even if packet bytes remain. `idle` is 0 after reset and is cleared by `tail_wr`.
- R8: Each walk ends with a one-cycle `done_valid`. At that point `done_bytes` equals the total of all mover request lengths. `cur_ptr` then holds the link word of the last descriptor written; it is unchanged if no descriptor was written. A zero-length packet ends at once with 0 bytes and no memory access.
- R9: A side-stream frame of exactly five beats replaces the held application words when its last beat arrives. A frame of any other length pulses `app_err` for one cycle, in the cycle after its last beat, and leaves the held words unchanged.
- R10: A mover request that is not yet accepted holds its address and length stable. A mover request and a memory access are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run control level |
| tail_ptr | input | AW | Tail descriptor pointer, loaded by `tail_wr` |
| tail_wr | input | 1 | Loads `tail_ptr` and clears `idle` |
| cur_ptr_in | input | AW | New current descriptor pointer |
| cur_wr | input | 1 | Loads `cur_ptr_in` when no walk is active |
| halted | output | 1 | Halted flag |
| idle | output | 1 | Tail reached flag |
| cur_ptr | output | AW | Current descriptor pointer |
| pkt_valid | input | 1 | Packet offered |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_ready | output | 1 | Packet accepted when high with `pkt_valid` |
| done_valid | output | 1 | Walk finished pulse |
| done_bytes | output | LEN_W | Bytes accepted by the finished walk |
| done_eof | output | 1 | Whole packet placed and frame ended |
| mv_valid | output | 1 | Data mover request |
| mv_addr | output | 32 | Destination buffer address |
| mv_len | output | LEN_W | Chunk length in bytes |
| mv_ready | input | 1 | Data mover accepts request |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| app_valid | input | 1 | Application word beat |
| app_data | input | 32 | Application word |
| app_last | input | 1 | Last beat of side-stream frame |
| app_err | output | 1 | Wrong-length side-stream frame pulse |

## Verification
The hardest case to reach is a packet that spans several descriptors and also meets a stop condition partway through the walk. Only then do the middle descriptors show complete without either frame flag, and the reported byte count fall short of the packet length. To get there, the stimulus builds an eight-entry descriptor ring with random chunk sizes. It chooses a tail a random distance from the start and sometimes plants an already-complete descriptor further along. It then offers packets longer than one buffer. Memory and mover responses stall at random, so each state is held for differing lengths of time.

// File: rtl/rx_sg_pkg.sv
package rx_sg_pkg;

    localparam int WORD_W    = 32;
    localparam int APP_WORDS = 5;

    // descriptor word offsets
    localparam int OFF_NEXT  = 0;
    localparam int OFF_BUF   = 1;
    localparam int OFF_CTRL  = 2;
    localparam int OFF_STAT  = 3;
    localparam int OFF_APP   = 4;

    // control / status field positions
    localparam int DLEN_BITS = 23;
    localparam int BIT_CMP   = 31;
    localparam int BIT_SOF   = 27;
    localparam int BIT_EOF   = 26;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        W_WAIT,
        W_RD_NEXT,
        W_RD_BUF,
        W_RD_CTRL,
        W_RD_STAT,
        W_MOVE,
        W_WR_APP,
        W_WR_STAT,
        W_DONE
    } walk_st_e;

    typedef struct packed {
        word_t                 nxt;
        word_t                 buf_a;
        word_t                 stat;
        logic [DLEN_BITS-1:0]  dlen;
    } desc_t;

    function automatic word_t stat_merge(word_t old, logic first, logic last);
        word_t r;
        r = old;
        r[BIT_CMP] = 1'b1;
        if (first) r[BIT_SOF] = 1'b1;
        if (last)  r[BIT_EOF] = 1'b1;
        return r;
    endfunction

    function automatic word_t min_word(word_t a, word_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/rx_ctrl_flags.sv
module rx_ctrl_flags #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_en,
    input  logic          tail_wr,
    input  logic [AW-1:0] tail_in,
    input  logic          set_idle,
    input  logic          set_halt,
    output logic          halted,
    output logic          idle,
    output logic [AW-1:0] tail_q
);

    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            halted <= 1'b1;
            idle   <= 1'b0;
            tail_q <= '0;
        end else begin
            run_q <= run_en;
            if (set_halt)
                halted <= 1'b1;
            else if (run_en && !run_q)
                halted <= 1'b0;
            if (tail_wr) begin
                idle   <= 1'b0;
                tail_q <= tail_in;
            end else if (set_idle) begin
                idle <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rx_app_capture.sv
module rx_app_capture
    import rx_sg_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              app_valid,
    input  word_t                             app_data,
    input  logic                              app_last,
    output logic [APP_WORDS-1:0][WORD_W-1:0]  app_words,
    output logic                              app_err
);

    localparam int CNT_W = $clog2(APP_WORDS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(APP_WORDS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(APP_WORDS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(APP_WORDS - 1);

    logic [CNT_W-1:0]                 cnt;
    logic [APP_WORDS-1:0][WORD_W-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            stage     <= '0;
            app_words <= '0;
            app_err   <= 1'b0;
        end else begin
            app_err <= 1'b0;
            if (app_valid) begin
                if (cnt < CNT_FULL)
                    stage[cnt] <= app_data;
                if (app_last) begin
                    cnt <= '0;
                    if (cnt == CNT_LAST) begin
                        for (int i = 0; i < APP_WORDS - 1; i++)
                            app_words[i] <= stage[i];
                        app_words[APP_WORDS-1] <= app_data;
                    end else begin
                        app_err <= 1'b1;
                    end
                end else if (cnt != CNT_OVER) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rx_desc_walker.sv
module rx_desc_walker
    import rx_sg_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LEN_W = 23
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              run_en,
    input  logic                              idle,
    input  logic [AW-1:0]                     tail_q,
    input  logic                              cur_wr,
    input  logic [AW-1:0]                     cur_ptr_in,
    input  logic                              pkt_valid,
    input  logic [LEN_W-1:0]                  pkt_len,
    output logic                              pkt_ready,
    output logic                              mem_req,
    output logic                              mem_we,
    output logic [AW-1:0]                     mem_addr,
    output word_t                             mem_wdata,
    input  word_t                             mem_rdata,
    input  logic                              mem_ack,
    output logic                              mv_valid,
    output word_t                             mv_addr,
    output logic [LEN_W-1:0]                  mv_len,
    input  logic                              mv_ready,
    input  logic [APP_WORDS-1:0][WORD_W-1:0]  app_words,
    output logic                              set_idle,
    output logic                              set_halt,
    output logic [AW-1:0]                     cur_ptr,
    output logic                              done_valid,
    output logic [LEN_W-1:0]                  done_bytes,
    output logic                              done_eof
);

    localparam int IDX_W = $clog2(APP_WORDS);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(APP_WORDS - 1);

    walk_st_e         st;
    desc_t            d;
    logic [AW-1:0]    cur;
    logic [LEN_W-1:0] rem, acc, chunk;
    logic             first, last, eof_seen;
    logic [IDX_W-1:0] idx;
    word_t            fit;

    assign fit = min_word(WORD_W'(d.dlen), WORD_W'(rem));

    always_comb begin
        pkt_ready  = (st == W_WAIT) && run_en && !idle;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur;
        mem_wdata  = '0;
        case (st)
            W_RD_NEXT: begin mem_req = 1'b1; mem_addr = cur + AW'(OFF_NEXT); end
            W_RD_BUF:  begin mem_req = 1'b1; mem_addr = cur + AW'(OFF_BUF);  end
            W_RD_CTRL: begin mem_req = 1'b1; mem_addr = cur + AW'(OFF_CTRL); end
            W_RD_STAT: begin mem_req = 1'b1; mem_addr = cur + AW'(OFF_STAT); end
            W_WR_APP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur + AW'(OFF_APP) + AW'(idx);
                mem_wdata = app_words[idx];
            end
            W_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cur + AW'(OFF_STAT);
                mem_wdata = stat_merge(d.stat, first, last);
            end
            default: ;
        endcase
        mv_valid   = (st == W_MOVE);
        mv_addr    = d.buf_a;
        mv_len     = chunk;
        set_halt   = (st == W_RD_STAT) && mem_ack && mem_rdata[BIT_CMP];
        set_idle   = (st == W_WR_STAT) && mem_ack && (cur == tail_q);
        done_valid = (st == W_DONE);
        done_bytes = acc;
        done_eof   = eof_seen;
        cur_ptr    = cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= W_WAIT;
            d        <= '0;
            cur      <= '0;
            rem      <= '0;
            acc      <= '0;
            chunk    <= '0;
            first    <= 1'b0;
            last     <= 1'b0;
            eof_seen <= 1'b0;
            idx      <= '0;
        end else begin
            case (st)
                W_WAIT: begin
                    if (cur_wr)
                        cur <= cur_ptr_in;
                    if (pkt_valid && pkt_ready) begin
                        rem      <= pkt_len;
                        acc      <= '0;
                        first    <= 1'b1;
                        last     <= 1'b0;
                        eof_seen <= 1'b0;
                        st       <= (pkt_len == '0) ? W_DONE : W_RD_NEXT;
                    end
                end
                W_RD_NEXT: if (mem_ack) begin
                    d.nxt <= mem_rdata;
                    st    <= W_RD_BUF;
                end
                W_RD_BUF: if (mem_ack) begin
                    d.buf_a <= mem_rdata;
                    st      <= W_RD_CTRL;
                end
                W_RD_CTRL: if (mem_ack) begin
                    d.dlen <= mem_rdata[DLEN_BITS-1:0];
                    st     <= W_RD_STAT;
                end
                W_RD_STAT: if (mem_ack) begin
                    if (mem_rdata[BIT_CMP]) begin
                        st <= W_DONE;
                    end else begin
                        d.stat <= mem_rdata;
                        chunk  <= fit[LEN_W-1:0];
                        st     <= W_MOVE;
                    end
                end
                W_MOVE: if (mv_ready) begin
                    rem  <= rem - chunk;
                    acc  <= acc + chunk;
                    last <= (chunk == rem);
                    idx  <= '0;
                    st   <= (chunk == rem) ? W_WR_APP : W_WR_STAT;
                end
                W_WR_APP: if (mem_ack) begin
                    if (idx == IDX_LAST)
                        st <= W_WR_STAT;
                    else
                        idx <= idx + 1'b1;
                end
                W_WR_STAT: if (mem_ack) begin
                    first <= 1'b0;
                    if (last)
                        eof_seen <= 1'b1;
                    cur <= d.nxt[AW-1:0];
                    st  <= (last || cur == tail_q) ? W_DONE : W_RD_NEXT;
                end
                W_DONE: st <= W_WAIT;
                default: st <= W_WAIT;
            endcase
        end
    end

endmodule

// File: rtl/rx_sg_writer.sv
module rx_sg_writer
    import rx_sg_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LEN_W = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [AW-1:0]    tail_ptr,
    input  logic             tail_wr,
    input  logic [AW-1:0]    cur_ptr_in,
    input  logic             cur_wr,
    output logic             halted,
    output logic             idle,
    output logic [AW-1:0]    cur_ptr,
    input  logic             pkt_valid,
    input  logic [LEN_W-1:0] pkt_len,
    output logic             pkt_ready,
    output logic             done_valid,
    output logic [LEN_W-1:0] done_bytes,
    output logic             done_eof,
    output logic             mv_valid,
    output logic [31:0]      mv_addr,
    output logic [LEN_W-1:0] mv_len,
    input  logic             mv_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    input  logic             app_valid,
    input  logic [31:0]      app_data,
    input  logic             app_last,
    output logic             app_err
);

    logic [APP_WORDS-1:0][WORD_W-1:0] app_words;
    logic                             set_idle, set_halt;
    logic [AW-1:0]                    tail_q;

    rx_ctrl_flags #(.AW(AW)) flags_i (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .tail_wr  (tail_wr),
        .tail_in  (tail_ptr),
        .set_idle (set_idle),
        .set_halt (set_halt),
        .halted   (halted),
        .idle     (idle),
        .tail_q   (tail_q)
    );

    rx_app_capture app_i (
        .clk       (clk),
        .rst       (rst),
        .app_valid (app_valid),
        .app_data  (app_data),
        .app_last  (app_last),
        .app_words (app_words),
        .app_err   (app_err)
    );

    rx_desc_walker #(.AW(AW), .LEN_W(LEN_W)) walk_i (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .idle       (idle),
        .tail_q     (tail_q),
        .cur_wr     (cur_wr),
        .cur_ptr_in (cur_ptr_in),
        .pkt_valid  (pkt_valid),
        .pkt_len    (pkt_len),
        .pkt_ready  (pkt_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack),
        .mv_valid   (mv_valid),
        .mv_addr    (mv_addr),
        .mv_len     (mv_len),
        .mv_ready   (mv_ready),
        .app_words  (app_words),
        .set_idle   (set_idle),
        .set_halt   (set_halt),
        .cur_ptr    (cur_ptr),
        .done_valid (done_valid),
        .done_bytes (done_bytes),
        .done_eof   (done_eof)
    );

endmodule

// File: rtl/rx_sg_writer_chk.sv
module rx_sg_writer_chk
    import rx_sg_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LEN_W = 23
) (
    input logic             clk,
    input logic             rst,
    input logic             run_en,
    input logic             idle,
    input logic             halted,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [LEN_W-1:0] pkt_len,
    input logic             mv_valid,
    input logic             mv_ready,
    input logic [LEN_W-1:0] mv_len,
    input logic [31:0]      mv_addr,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [AW-1:0]    mem_addr,
    input logic [AW-1:0]    cur_ptr,
    input logic             wr_cmp,
    input logic             rd_cmp,
    input logic             done_valid,
    input logic [LEN_W-1:0] done_bytes,
    input logic             app_valid,
    input logic             app_last,
    input logic             app_err
);

    logic [LEN_W-1:0] len_cap;

    always_ff @(posedge clk) begin
        if (rst)
            len_cap <= '0;
        else if (pkt_valid && pkt_ready)
            len_cap <= pkt_len;
    end

    AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        pkt_ready |-> (run_en && !idle)); // R1

    AST_MOVE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        mv_valid |-> (mv_len <= len_cap)); // R2

    AST_STAT_COMPLETE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr == cur_ptr + AW'(OFF_STAT)) |-> wr_cmp); // R3

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(mem_req && !mem_we && mem_ack && rd_cmp)); // R6

    AST_DONE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_bytes <= len_cap)); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        app_err |-> $past(app_valid && app_last)); // R9

    AST_MOVE_HELD: assert property (@(posedge clk) disable iff (rst)
        (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_len) && $stable(mv_addr))); // R10

    AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && mv_valid)); // R10

endmodule

bind rx_sg_writer rx_sg_writer_chk #(.AW(AW), .LEN_W(LEN_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .idle       (idle),
    .halted     (halted),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_len    (pkt_len),
    .mv_valid   (mv_valid),
    .mv_ready   (mv_ready),
    .mv_len     (mv_len),
    .mv_addr    (mv_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .cur_ptr    (cur_ptr),
    .wr_cmp     (mem_wdata[31]),
    .rd_cmp     (mem_rdata[31]),
    .done_valid (done_valid),
    .done_bytes (done_bytes),
    .app_valid  (app_valid),
    .app_last   (app_last),
    .app_err    (app_err)
);

// File: tb/rx_sg_writer_tb_top.sv
module rx_sg_writer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int LEN_W      = 23;
    localparam int NDESC      = 8;
    localparam int STRIDE     = 16;

    logic             clk = 1'b0;
    logic             rst, run_en, tail_wr, cur_wr;
    logic [AW-1:0]    tail_ptr, cur_ptr_in, cur_ptr, mem_addr;
    logic             halted, idle, pkt_valid, pkt_ready, done_valid, done_eof;
    logic [LEN_W-1:0] pkt_len, done_bytes, mv_len;
    logic             mv_valid, mv_ready, mem_req, mem_we, mem_ack, ack_en;
    logic [31:0]      mv_addr, mem_wdata, mem_rdata, app_data;
    logic             app_valid, app_last, app_err;

    logic [31:0]      mem [256];
    logic [31:0]      app_cur [5];
    logic [31:0]      lg_addr [64];
    logic [LEN_W-1:0] lg_len [64];
    int               mv_n = 0;

    // expected results
    logic [31:0]      exp_stat [NDESC];
    logic [31:0]      exp_addr [16];
    int               exp_chunk [16];
    int               exp_n, exp_bytes, exp_eof_i, exp_cur, cur_tail;
    logic             exp_idle, exp_halt;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_sg_writer #(.AW(AW), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .run_en(run_en), .tail_ptr(tail_ptr), .tail_wr(tail_wr),
        .cur_ptr_in(cur_ptr_in), .cur_wr(cur_wr), .halted(halted), .idle(idle),
        .cur_ptr(cur_ptr), .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_ready(pkt_ready),
        .done_valid(done_valid), .done_bytes(done_bytes), .done_eof(done_eof),
        .mv_valid(mv_valid), .mv_addr(mv_addr), .mv_len(mv_len), .mv_ready(mv_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .app_valid(app_valid),
        .app_data(app_data), .app_last(app_last), .app_err(app_err)
    );

    // memory and mover responders with random stalls
    assign mem_ack   = mem_req & ack_en;
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(negedge clk) begin
        ack_en   = ($urandom % 4) != 0;
        mv_ready = ($urandom % 3) != 0;
    end

    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack)
            mem[mem_addr[7:0]] <= mem_wdata;
        if (mv_valid && mv_ready) begin
            lg_addr[mv_n % 64] <= mv_addr;
            lg_len[mv_n % 64]  <= mv_len;
            mv_n <= mv_n + 1;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog expired act=1 exp=0");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic send_app(input int n, input logic [31:0] base, output logic err);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            app_valid = 1'b1;
            app_data  = base + 32'(k);
            app_last  = (k == n - 1);
        end
        @(negedge clk);
        app_valid = 1'b0;
        app_last  = 1'b0;
        err = app_err;
        if (n == 5)
            for (int k = 0; k < 5; k++) app_cur[k] = base + 32'(k);
    endtask

    task automatic init_ring();
        for (int i = 0; i < NDESC; i++) begin
            mem[i*STRIDE]     = 32'(((i + 1) % NDESC) * STRIDE);
            mem[i*STRIDE + 1] = 32'hB000_0000 + 32'(i * 256) + ($urandom & 32'hFF);
            mem[i*STRIDE + 2] = ($urandom & 32'hFF80_0000) | 32'(1 + $urandom % 200);
            mem[i*STRIDE + 3] = $urandom & 32'h03FF_FFFF;
            for (int k = 4; k < 9; k++) mem[i*STRIDE + k] = 32'h0;
        end
    endtask

    task automatic set_len(input int i, input int len);
        mem[i*STRIDE + 2] = (mem[i*STRIDE + 2] & 32'hFF80_0000) | 32'(len);
    endtask

    task automatic setup(input int start, input int tail);
        @(negedge clk);
        cur_wr     = 1'b1;
        cur_ptr_in = AW'(start * STRIDE);
        tail_wr    = 1'b1;
        tail_ptr   = AW'(tail * STRIDE);
        cur_tail   = tail * STRIDE;
        @(negedge clk);
        cur_wr  = 1'b0;
        tail_wr = 1'b0;
    endtask

    // reference walk computed from the requirements
    task automatic model(input int start, input int len);
        int cur, rem, ch, dl, prev;
        logic first, last;
        logic [31:0] st;
        for (int i = 0; i < NDESC; i++) exp_stat[i] = mem[i*STRIDE + 3];
        cur = start * STRIDE; rem = len; first = 1'b1;
        exp_n = 0; exp_bytes = 0; exp_eof_i = -1;
        exp_idle = 1'b0; exp_halt = halted;
        exp_cur = int'(cur_ptr);
        while (rem > 0) begin
            st = mem[cur + 3];
            if (st[31]) begin
                exp_halt = 1'b1;
                break;
            end
            dl = int'(mem[cur + 2] & 32'h007F_FFFF);
            ch = (dl < rem) ? dl : rem;
            exp_chunk[exp_n] = ch;
            exp_addr[exp_n]  = mem[cur + 1];
            exp_n++;
            rem -= ch;
            exp_bytes += ch;
            last = (rem == 0);
            st[31] = 1'b1;
            if (first) st[27] = 1'b1;
            if (last) begin
                st[26] = 1'b1;
                exp_eof_i = cur / STRIDE;
            end
            exp_stat[cur / STRIDE] = st;
            first = 1'b0;
            prev = cur;
            cur = int'(mem[cur]);
            exp_cur = cur;
            if (prev == cur_tail) begin
                exp_idle = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_pkt(input int start, input int len);
        int base;
        model(start, len);
        base = mv_n;
        pkt_valid = 1'b1;
        pkt_len   = LEN_W'(len);
        while (!pkt_ready) @(negedge clk);
        @(negedge clk);
        pkt_valid = 1'b0;
        while (!done_valid) @(negedge clk);
        chk("R8 done_bytes", 32'(done_bytes), 32'(exp_bytes));
        chk("R5 done_eof", 32'(done_eof), 32'(exp_eof_i >= 0));
        @(negedge clk);
        chk("R8 cur_ptr", 32'(cur_ptr), 32'(exp_cur));
        chk("R7 idle", 32'(idle), 32'(exp_idle));
        chk("R6 halted", 32'(halted), 32'(exp_halt));
        for (int i = 0; i < NDESC; i++)
            chk("R3 R4 R5 status", mem[i*STRIDE + 3], exp_stat[i]);
        chk("R2 request count", 32'(mv_n - base), 32'(exp_n));
        for (int j = 0; j < exp_n && j < mv_n - base; j++) begin
            chk("R2 chunk len", 32'(lg_len[(base + j) % 64]), 32'(exp_chunk[j]));
            chk("R2 chunk addr", lg_addr[(base + j) % 64], exp_addr[j]);
        end
        if (exp_eof_i >= 0)
            for (int k = 0; k < 5; k++)
                chk("R5 R9 app word", mem[exp_eof_i*STRIDE + 4 + k], app_cur[k]);
    endtask

    initial begin
        logic err;
        int start, tail;
        void'($urandom(32'd4242));
        rst = 1'b1; run_en = 1'b0; tail_wr = 1'b0; cur_wr = 1'b0;
        tail_ptr = '0; cur_ptr_in = '0; pkt_valid = 1'b0; pkt_len = '0;
        app_valid = 1'b0; app_data = '0; app_last = 1'b0; cur_tail = 0;
        for (int k = 0; k < 5; k++) app_cur[k] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 reset halted", 32'(halted), 32'd1);
        chk("R7 reset idle", 32'(idle), 32'd0);
        chk("R1 reset ready", 32'(pkt_ready), 32'd0);
        chk("R8 reset mem_req", 32'(mem_req), 32'd0);
        run_en = 1'b1;
        @(negedge clk);
        chk("R6 halted cleared by run", 32'(halted), 32'd0);
        chk("R1 ready when running", 32'(pkt_ready), 32'd1);

        send_app(5, 32'hA000_0010, err);
        chk("R9 good frame no error", 32'(err), 32'd0);

        // single descriptor holds packet
        init_ring(); set_len(0, 200); setup(0, 7); run_pkt(0, 100);
        // exact fit
        init_ring(); set_len(0, 64); setup(0, 7); run_pkt(0, 64);
        // three descriptors, last one partly used
        init_ring(); set_len(0, 40); set_len(1, 60); set_len(2, 500);
        setup(0, 7); run_pkt(0, 300);
        // zero-length packet
        init_ring(); setup(0, 7); run_pkt(0, 0);

        // wrong-length side frames keep old words
        send_app(4, 32'hC000_0000, err);
        chk("R9 short frame error", 32'(err), 32'd1);
        send_app(6, 32'hD000_0000, err);
        chk("R9 long frame error", 32'(err), 32'd1);
        init_ring(); set_len(2, 300); setup(2, 7); run_pkt(2, 150);

        // tail reached with bytes left
        init_ring(); set_len(0, 50); set_len(1, 50); setup(0, 1); run_pkt(0, 300);
        chk("R1 R7 ready low while idle", 32'(pkt_ready), 32'd0);
        setup(2, 7);
        chk("R7 idle cleared by tail write", 32'(idle), 32'd0);

        // already-complete descriptor after one used
        init_ring(); set_len(2, 20); mem[3*STRIDE + 3] |= 32'h8000_0000;
        setup(2, 7); run_pkt(2, 100);
        run_en = 1'b0;
        @(negedge clk);
        chk("R1 ready low when stopped", 32'(pkt_ready), 32'd0);
        run_en = 1'b1;
        @(negedge clk);
        chk("R6 halted cleared on restart", 32'(halted), 32'd0);

        // constrained random walks
        for (int it = 0; it < 30; it++) begin
            init_ring();
            start = $urandom % NDESC;
            tail  = (start + $urandom % NDESC) % NDESC;
            if ($urandom % 5 == 0)
                mem[((start + 1 + $urandom % 6) % NDESC)*STRIDE + 3] |= 32'h8000_0000;
            if ($urandom % 4 == 0) begin
                send_app(5, $urandom, err);
                chk("R9 random good frame", 32'(err), 32'd0);
            end
            setup(start, tail);
            run_pkt(start, 1 + $urandom % 700);
            if (halted) begin
                run_en = 1'b0;
                @(negedge clk);
                run_en = 1'b1;
                @(negedge clk);
            end
        end

        summary();
        $finish;
    end

endmodule